// File: doc/BRIEF.md
# Packet Loopback Region Controller

This controller lives inside one processing region and returns each packet it receives to the host. Ingress words arrive on a valid/ready stream. The first beat of a packet also carries a tracking tag, and the final beat is flagged. Each word is written into a local packet memory, and the stored word count is latched when the packet ends. The controller works in half-duplex: while a packet is being received or sent back, no other transfer in the opposite direction is started.

After reception ends, the controller waits for a completion pulse from the central dispatcher. It then raises a transmit request and waits for the dispatcher's acknowledge. Once acknowledged, it plays the packet out on an egress valid/ready stream that feeds an egress FIFO write port. The tag goes out first as a header beat, and the stored words follow in address order. `out_ready` is the inverse of the FIFO full flag.

Back-pressure rules: an ingress beat is taken on a cycle where `in_valid` and `in_ready` are both high. An egress beat is delivered on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the egress beat is held unchanged. A stall freezes the address walk, and no beat is lost or repeated.

Top module: `lb_region_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, `xmit_req` is 0, `out_valid` is 0 and `overflow` is 0.
- R2: In the receive phase `in_ready` is 1 and every accepted beat is stored in arrival order. The beat with `in_last`=1 ends the packet. From the next cycle `in_ready` is 0 and stays 0 until the egress transfer completes.
- R3: A `done_in` pulse during reception is ignored. Only a `done_in` sampled after the packet has ended counts, and `xmit_req` rises on the cycle after it.
- R4: `ack_in` has no effect while `xmit_req` is 0. No egress beat appears before an acknowledge has been taken while `xmit_req` is 1.
- R5: The first egress beat is the header. It has `out_hdr`=1, and `out_data` holds the tag captured with the packet's first ingress beat, zero-extended in the low bits.
- R6: The header is followed by the stored words in arrival order, each with `out_hdr`=0. `out_last`=1 marks only the final stored word. The egress stream has one beat more than the stored word count.
- R7: While `out_valid`=1 and `out_ready`=0, the next cycle still shows `out_valid`=1 with the same `out_data`, `out_hdr` and `out_last`.
- R8: On the cycle after the final egress beat is delivered, `xmit_req` is 0 and `in_ready` is 1, so a new packet can be received.
- R9: A packet longer than `DEPTH` words keeps only its first `DEPTH` words, and the remaining beats are accepted and discarded. `overflow` then goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress beat valid |
| in_ready | output | 1 | Ingress beat accepted when high with valid |
| in_data | input | DATA_W | Ingress word |
| in_tag | input | TAG_W | Tracking tag, sampled with the first beat of a packet |
| in_last | input | 1 | Final beat of the packet |
| done_in | input | 1 | Dispatcher pulse: ingress complete |
| ack_in | input | 1 | Dispatcher acknowledge of the transmit request |
| xmit_req | output | 1 | Transmit request, held until the final egress beat is delivered |
| out_valid | output | 1 | Egress beat valid |
| out_ready | input | 1 | Egress FIFO not full |
| out_data | output | DATA_W | Egress word (tag on the header beat) |
| out_hdr | output | 1 | Marks the header beat |
| out_last | output | 1 | Marks the final egress beat |
| overflow | output | 1 | Sticky: a packet exceeded memory depth |

## Verification
Two things can happen in the same cycle: the egress walk can advance, and the FIFO full flag can rise. A back-pressure pattern is applied to `out_ready` throughout a packet, so stalls land on the header, in the middle of the payload, and on the final word. A scoreboard then requires the beat order to stay intact, and it requires a stalled beat to stay the same until it is taken. The second overlap is a dispatcher pulse that arrives while the block is busy with something else. `done_in` is pulsed in the middle of reception and `ack_in` before any request. The bench then confirms at the ports that neither pulse moved the handshake forward.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_SEND = 2'd3
  } lb_state_t;
endpackage

// File: rtl/lb_pkt_mem.sv
module lb_pkt_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // read register holds its value unless a read is issued
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/lb_ingress_wr.sv
module lb_ingress_wr #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              in_ready,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pkt_end,
  output logic [CW-1:0]     pkt_len,
  output logic [TAG_W-1:0]  pkt_tag,
  output logic              ovf
);
  logic [CW-1:0] cnt_q;
  logic          fire;
  logic          room;

  assign in_ready = active;
  assign fire     = active && in_valid;
  assign room     = cnt_q < CW'(DEPTH);
  assign wr_en    = fire && room;
  assign wr_addr  = cnt_q[AW-1:0];
  assign wr_data  = in_data;
  assign pkt_end  = fire && in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pkt_len <= '0;
      pkt_tag <= '0;
      ovf     <= 1'b0;
    end else if (fire) begin
      if (cnt_q == '0) pkt_tag <= in_tag;
      if (!room) ovf <= 1'b1;
      if (in_last) begin
        cnt_q   <= '0;
        pkt_len <= room ? cnt_q + CW'(1) : cnt_q;
      end else if (room) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R9
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R9
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_end) |-> (pkt_len <= CW'(DEPTH)) && (pkt_len != '0));
endmodule

// File: rtl/lb_egress_rd.sv
module lb_egress_rd #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CW-1:0]     pkt_len,
  input  logic [TAG_W-1:0]  pkt_tag,
  input  logic [DATA_W-1:0] mem_q,
  input  logic              out_ready,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_hdr,
  output logic              out_last,
  output logic              xfer_done
);
  logic [CW-1:0]     idx_q;
  logic              adv;
  logic              more;
  logic [CW-1:0]     idx_m1;
  logic [DATA_W-1:0] tag_word;

  generate
    if (TAG_W == DATA_W) begin : g_tag_full
      assign tag_word = pkt_tag;
    end else begin : g_tag_pad
      assign tag_word = {{(DATA_W-TAG_W){1'b0}}, pkt_tag};
    end
  endgenerate

  assign adv       = active && (!out_valid || out_ready);
  assign more      = idx_q <= pkt_len;
  assign idx_m1    = idx_q - CW'(1);
  assign rd_en     = adv && more && (idx_q != '0);
  assign rd_addr   = idx_m1[AW-1:0];
  assign out_data  = out_hdr ? tag_word : mem_q;
  assign xfer_done = out_valid && out_ready && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_hdr   <= 1'b0;
      out_last  <= 1'b0;
    end else if (!active) begin
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_hdr   <= 1'b0;
      out_last  <= 1'b0;
    end else if (adv) begin
      if (more) begin
        out_valid <= 1'b1;
        out_hdr   <= (idx_q == '0);
        out_last  <= (idx_q == pkt_len);
        idx_q     <= idx_q + CW'(1);
      end else begin
        out_valid <= 1'b0;
        out_hdr   <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
                                  $stable(out_hdr) && $stable(out_last));

  // R6
  rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (CW'(rd_addr) < pkt_len));

  // R5
  hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_hdr);
endmodule

// File: rtl/lb_region_ctrl.sv
module lb_region_ctrl #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_last,
  input  logic              done_in,
  input  logic              ack_in,
  output logic              xmit_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_hdr,
  output logic              out_last,
  output logic              overflow
);
  import lb_pkg::*;

  lb_state_t         state_q, state_d;
  logic              wr_en, rd_en, pkt_end, xfer_done;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, mem_q;
  logic [CW-1:0]     pkt_len;
  logic [TAG_W-1:0]  pkt_tag;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RX:   if (pkt_end)   state_d = ST_WAIT;
      ST_WAIT: if (done_in)   state_d = ST_REQ;
      ST_REQ:  if (ack_in)    state_d = ST_SEND;
      ST_SEND: if (xfer_done) state_d = ST_RX;
      default:                state_d = ST_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RX;
    else        state_q <= state_d;
  end

  assign xmit_req = (state_q == ST_REQ) || (state_q == ST_SEND);

  lb_ingress_wr #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_ing (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (state_q == ST_RX),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_data  (in_data),
    .in_tag   (in_tag),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pkt_end  (pkt_end),
    .pkt_len  (pkt_len),
    .pkt_tag  (pkt_tag),
    .ovf      (overflow)
  );

  lb_pkt_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (mem_q)
  );

  lb_egress_rd #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_egr (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (state_q == ST_SEND),
    .pkt_len   (pkt_len),
    .pkt_tag   (pkt_tag),
    .mem_q     (mem_q),
    .out_ready (out_ready),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_hdr   (out_hdr),
    .out_last  (out_last),
    .xfer_done (xfer_done)
  );

  // R3
  req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit_req) |-> $past(done_in));

  // R4
  egress_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> xmit_req);

  // R2
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xmit_req) |-> $past(out_valid && out_ready && out_last) && in_ready);
endmodule

// File: tb/lb_region_ctrl_bench.sv
module lb_region_ctrl_bench;
  localparam int DW = 16;
  localparam int TW = 8;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, done_in = 1'b0, ack_in = 1'b0;
  logic out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [TW-1:0] in_tag = '0;
  logic in_ready, xmit_req, out_valid, out_hdr, out_last, overflow;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [DW+1:0] exp_q[$];

  always #2.5 clk = ~clk;

  lb_region_ctrl #(.DATA_W(DW), .TAG_W(TW), .DEPTH(DEP)) u_lb_region_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tag(in_tag), .in_last(in_last), .done_in(done_in),
    .ack_in(ack_in), .xmit_req(xmit_req), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_hdr(out_hdr),
    .out_last(out_last), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // back-pressure generator
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic chk_fall = 1'b0;
  logic prev_stall = 1'b0;
  logic [DW+1:0] prev_beat;
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (chk_fall) begin
        // R8
        chk(!xmit_req && in_ready, "R8", {xmit_req, in_ready}, 2'b01);
        chk_fall = 1'b0;
      end
      if (prev_stall) begin
        // R7
        chk(out_valid && {out_hdr, out_last, out_data} == prev_beat, "R7",
            {out_valid, out_hdr, out_last, out_data}, {1'b1, prev_beat});
      end
      prev_stall = out_valid && !out_ready;
      prev_beat  = {out_hdr, out_last, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", {out_hdr, out_last, out_data}, 0);
        end else begin
          logic [DW+1:0] e;
          e = exp_q.pop_front();
          if (e[DW+1])
            chk({out_hdr, out_last, out_data} == e, "R5", {out_hdr, out_last, out_data}, e);
          else
            chk({out_hdr, out_last, out_data} == e, "R6", {out_hdr, out_last, out_data}, e);
        end
        if (out_last) chk_fall = 1'b1;
      end
    end
  end

  // watchdog
  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic send_pkt(input logic [TW-1:0] tag, input int n,
                          input logic [DW-1:0] seed, input bit poke_done);
    int kept;
    kept = (n < DEP) ? n : DEP;
    exp_q.push_back({1'b1, 1'b0, {(DW-TW){1'b0}}, tag});
    for (int i = 0; i < kept; i++)
      exp_q.push_back({1'b0, (i == kept - 1), DW'(seed + DW'(i * 3))});
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = DW'(seed + DW'(i * 3));
      in_tag   = (i == 0) ? tag : ~tag;
      in_last  = (i == n - 1);
      done_in  = poke_done && (i == 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0; done_in = 1'b0;
    @(negedge clk);
    // R2
    chk(!in_ready, "R2", in_ready, 0);
  endtask

  task automatic loop_back();
    repeat (3) @(negedge clk);
    // R3: done pulse during reception must not have counted
    chk(!xmit_req, "R3", xmit_req, 0);
    @(posedge clk); #1 ack_in = 1'b1;
    @(posedge clk); #1 ack_in = 1'b0;
    @(negedge clk);
    // R4
    chk(!xmit_req && !out_valid, "R4", {xmit_req, out_valid}, 0);
    @(posedge clk); #1 done_in = 1'b1;
    @(posedge clk); #1 done_in = 1'b0;
    @(negedge clk);
    // R3
    chk(xmit_req, "R3", xmit_req, 1);
    repeat (3) @(negedge clk);
    // R4
    chk(!out_valid && xmit_req, "R4", {out_valid, xmit_req}, 2'b01);
    @(posedge clk); #1 ack_in = 1'b1;
    @(posedge clk); #1 ack_in = 1'b0;
    for (int w = 0; w < 2000 && (exp_q.size() != 0 || xmit_req); w++)
      @(negedge clk);
    // R6
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    // R2
    chk(in_ready && !out_valid, "R2", {in_ready, out_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(in_ready && !xmit_req && !out_valid && !overflow, "R1",
        {in_ready, xmit_req, out_valid, overflow}, 4'b1000);

    send_pkt(8'h5A, 4, 16'h1000, 1'b1);
    loop_back();

    bp_en = 1'b1;
    send_pkt(8'hC3, 7, 16'h2200, 1'b0);
    loop_back();
    send_pkt(8'h01, 1, 16'hBEEF, 1'b1);
    loop_back();
    // R9 not yet set
    chk(!overflow, "R9", overflow, 0);

    send_pkt(8'h7E, DEP + 3, 16'h3000, 1'b0);
    loop_back();
    // R9
    chk(overflow, "R9", overflow, 1);

    bp_en = 1'b0;
    send_pkt(8'h99, DEP, 16'h4400, 1'b0);
    loop_back();
    // R9 sticky
    chk(overflow, "R9", overflow, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule